// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block chooses where an atomic memory operation should execute. Each request carries a cache-block address and the ID of the core that issued it. The answer is either *local*, meaning the operation runs in the requesting core's L1 cache, or *far*, meaning it is sent to an outer cache level or to memory. The predictor only makes this choice. Executing the operation, keeping caches coherent and steering the request are done elsewhere.

The predictor keeps a direct-mapped history table. The low bits of the block address select an entry, and the remaining address bits are stored as a tag. Each entry records which core touched the block last and holds a saturating count of how many times in a row that core has come back. A block that one core keeps reusing is moved into that core's L1. A miss, or a different core arriving, sends the operation far and starts a new streak.

Each request produces a registered decision one clock later. The table is written on the same edge, so a request in the very next cycle sees the updated entry.

Top module: `atomic_place_predictor`

## Requirements
- R1: A synchronous reset invalidates every table entry and clears `dec_valid` and `dec_local`. The first request to any block after reset is therefore decided far (`dec_local` = 0).
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1. When `dec_valid` is 1, `dec_local` = 1 means local and 0 means far.
- R3: If the selected entry is invalid, or its tag differs from the request's tag, the decision is far. The entry is then loaded with the request's tag and core, and its count is set to 0.
- R4: If the tag matches and the requesting core equals the recorded core, the count increases by one.
- R5: The decision is local only when the tag matches, the core equals the recorded core, and the count after the increment is greater than `LIMIT`. With the default `LIMIT` of 3, the fifth consecutive request from one core to one block is the first local one.
- R6: If the tag matches but the requesting core differs from the recorded core, the decision is far. The recorded core becomes the new requester and the count is set to 0.
- R7: The entry index is `req_block_addr[IDX_W-1:0]` and the tag is the remaining upper bits. Two blocks that share an index evict each other.
- R8: The count saturates at 2^`CNT_W` − 1, so a continuing streak stays local.
- R9: Back-to-back requests to the same entry in consecutive cycles each see the state left by the request before.
- R10: A cycle with `req_valid` = 0 leaves the table unchanged and gives `dec_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_block_addr | input | ADDR_W | Cache-block address of the atomic operation |
| req_core | input | CORE_W | ID of the requesting core |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_local | output | 1 | 1 = execute in L1, 0 = send far |

## Verification
The bench drives one core's streak to the exact request where the decision turns local. A design with an off-by-one in the limit comparison would flip one request early or late. It then keeps the streak going past the counter maximum: a count that wraps instead of saturating would fall back to far. Two further sequences break a streak, one by sending a request from a second core and one by sending a request to an aliasing block. A design that failed to clear the count, or that ignored the tag, would wrongly stay local. Idle gaps placed inside a streak, back-to-back requests, and a reset in the middle of a run catch designs that update the table without a valid request, read stale state, or keep entries alive across reset.

// File: rtl/apred_pkg.sv
package apred_pkg;

    // Result of looking up a request in the history table.
    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,   // invalid entry or different tag
        LK_SAME  = 2'd1,   // tag hit, same core as recorded
        LK_OTHER = 2'd2    // tag hit, different core
    } lookup_e;

    // Where the atomic operation is to execute.
    typedef enum logic {
        PLACE_FAR   = 1'b0,
        PLACE_LOCAL = 1'b1
    } place_e;

endpackage

// File: rtl/apred_addr_split.sv
module apred_addr_split #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] block_addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Low bits select the table entry; the rest identify the block.
    assign idx = block_addr[IDX_W-1:0];
    assign tag = block_addr[ADDR_W-1:IDX_W];

endmodule

// File: rtl/apred_table.sv
module apred_table #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 22,
    parameter int CORE_W  = 3,
    parameter int CNT_W   = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [CORE_W-1:0] rd_owner,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [CORE_W-1:0] wr_owner,
    input  logic [CNT_W-1:0]  wr_cnt
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [CORE_W-1:0] owner;
        logic [CNT_W-1:0]  cnt;
    } entry_t;

    entry_t ent_all [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        entry_t ent_d;
        entry_t ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_d.valid = 1'b1;
                ent_d.tag   = wr_tag;
                ent_d.owner = wr_owner;
                ent_d.cnt   = wr_cnt;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_all[i] = ent_q;
    end

    entry_t rd_ent;

    always_comb begin
        rd_ent   = ent_all[rd_idx];
        rd_valid = rd_ent.valid;
        rd_tag   = rd_ent.tag;
        rd_owner = rd_ent.owner;
        rd_cnt   = rd_ent.cnt;
    end

endmodule

// File: rtl/apred_decide.sv
module apred_decide
    import apred_pkg::*;
#(
    parameter int TAG_W  = 22,
    parameter int CORE_W = 3,
    parameter int CNT_W  = 3,
    parameter int LIMIT  = 3
) (
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [CORE_W-1:0] rd_owner,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [CORE_W-1:0] req_core,
    output lookup_e           lk,
    output logic [CNT_W-1:0]  nx_cnt,
    output place_e            place
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(LIMIT);

    always_comb begin
        if (!rd_valid || (rd_tag != req_tag)) begin
            lk = LK_MISS;
        end else if (rd_owner == req_core) begin
            lk = LK_SAME;
        end else begin
            lk = LK_OTHER;
        end

        // A streak only grows on a same-core hit; anything else restarts it.
        if (lk == LK_SAME) begin
            nx_cnt = (rd_cnt == CNT_MAX) ? CNT_MAX : rd_cnt + 1'b1;
        end else begin
            nx_cnt = '0;
        end

        place = ((lk == LK_SAME) && (nx_cnt > LIM_V)) ? PLACE_LOCAL : PLACE_FAR;
    end

endmodule

// File: rtl/atomic_place_predictor.sv
module atomic_place_predictor
    import apred_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int CORE_W  = 3,
    parameter int CNT_W   = 3,
    parameter int LIMIT   = 3,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_block_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              dec_valid,
    output logic              dec_local
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic vld;
        logic loc;
    } out_t;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [CORE_W-1:0] rd_owner;
    logic [CNT_W-1:0]  rd_cnt;
    lookup_e           lk;
    logic [CNT_W-1:0]  nx_cnt;
    place_e            place;

    out_t out_d;
    out_t out_q;

    apred_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_split (
        .block_addr (req_block_addr),
        .idx        (req_idx),
        .tag        (req_tag)
    );

    apred_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .CORE_W  (CORE_W),
        .CNT_W   (CNT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_owner (rd_owner),
        .rd_cnt   (rd_cnt),
        .wr_en    (req_valid),
        .wr_idx   (req_idx),
        .wr_tag   (req_tag),
        .wr_owner (req_core),
        .wr_cnt   (nx_cnt)
    );

    apred_decide #(
        .TAG_W  (TAG_W),
        .CORE_W (CORE_W),
        .CNT_W  (CNT_W),
        .LIMIT  (LIMIT)
    ) u_decide (
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_owner (rd_owner),
        .rd_cnt   (rd_cnt),
        .req_tag  (req_tag),
        .req_core (req_core),
        .lk       (lk),
        .nx_cnt   (nx_cnt),
        .place    (place)
    );

    always_comb begin
        out_d.vld = req_valid;
        out_d.loc = req_valid && (place == PLACE_LOCAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_valid = out_q.vld;
    assign dec_local = out_q.loc;

endmodule

// File: rtl/apred_checker.sv
module apred_checker
    import apred_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int LIMIT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input lookup_e          lk,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [CNT_W-1:0] nx_cnt,
    input logic             dec_valid,
    input logic             dec_local
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(LIMIT);

    p_dec_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_valid);

    p_miss_far_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_MISS) |=> !dec_local);

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_MISS) |-> nx_cnt == '0);

    p_other_far_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_OTHER) |=> !dec_local);

    p_other_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_OTHER) |-> nx_cnt == '0);

    p_same_incr_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_SAME && rd_cnt != CNT_MAX) |-> nx_cnt == rd_cnt + 1'b1);

    p_same_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_SAME && rd_cnt == CNT_MAX) |-> nx_cnt == CNT_MAX);

    p_local_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk == LK_SAME && rd_cnt >= LIM_V) |=> dec_local);

    p_local_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (lk != LK_SAME || rd_cnt < LIM_V)) |=> !dec_local);

endmodule

bind atomic_place_predictor apred_checker #(
    .CNT_W (CNT_W),
    .LIMIT (LIMIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .lk        (lk),
    .rd_cnt    (rd_cnt),
    .nx_cnt    (nx_cnt),
    .dec_valid (dec_valid),
    .dec_local (dec_local)
);

// File: tb/atomic_place_predictor_tb.sv
module atomic_place_predictor_tb;

    localparam int ADDR_W  = 16;
    localparam int CORE_W  = 3;
    localparam int CNT_W   = 3;
    localparam int LIMIT   = 3;
    localparam int ENTRIES = 16;
    localparam int NVEC    = 24;
    localparam int VEC_W   = 1 + ADDR_W + CORE_W + 1;

    // {valid, block address, core, expected local}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {1'b1, 16'h0012, 3'd1, 1'b0},  //  0 R3 miss allocates
        {1'b1, 16'h0012, 3'd1, 1'b0},  //  1 R4 count 1
        {1'b1, 16'h0012, 3'd1, 1'b0},  //  2 count 2
        {1'b1, 16'h0012, 3'd1, 1'b0},  //  3 count 3 = LIMIT, still far
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  4 R5 count 4 > LIMIT
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  5 count 5
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  6 count 6
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  7 count 7 (max)
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  8 R8 saturated
        {1'b1, 16'h0012, 3'd1, 1'b1},  //  9 R8 still saturated
        {1'b1, 16'h0012, 3'd2, 1'b0},  // 10 R6 other core
        {1'b1, 16'h0012, 3'd1, 1'b0},  // 11 R6 other core again
        {1'b1, 16'h0012, 3'd1, 1'b0},  // 12 count 1
        {1'b0, 16'h0012, 3'd5, 1'b0},  // 13 R10 idle with a foreign core
        {1'b1, 16'h0012, 3'd1, 1'b0},  // 14 count 2
        {1'b1, 16'h0012, 3'd1, 1'b0},  // 15 count 3
        {1'b1, 16'h0012, 3'd1, 1'b1},  // 16 count 4, idle left state alone
        {1'b1, 16'h0112, 3'd1, 1'b0},  // 17 R7 alias on index 2 evicts
        {1'b1, 16'h0012, 3'd1, 1'b0},  // 18 R7 original block misses
        {1'b1, 16'h0005, 3'd3, 1'b0},  // 19 R9 new block, back to back
        {1'b1, 16'h0005, 3'd3, 1'b0},  // 20 count 1
        {1'b1, 16'h0005, 3'd3, 1'b0},  // 21 count 2
        {1'b1, 16'h0005, 3'd3, 1'b0},  // 22 count 3
        {1'b1, 16'h0005, 3'd3, 1'b1}   // 23 R9 count 4 local
    };

    logic              clk;
    logic              rst;
    logic              req_valid;
    logic [ADDR_W-1:0] req_block_addr;
    logic [CORE_W-1:0] req_core;
    logic              dec_valid;
    logic              dec_local;

    int  n_checks;
    int  n_fails;
    bit  finished;

    atomic_place_predictor #(
        .ADDR_W  (ADDR_W),
        .CORE_W  (CORE_W),
        .CNT_W   (CNT_W),
        .LIMIT   (LIMIT),
        .ENTRIES (ENTRIES)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_block_addr (req_block_addr),
        .req_core       (req_core),
        .dec_valid      (dec_valid),
        .dec_local      (dec_local)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp, input int step);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s step %0d: actual %0b expected %0b", req, step, act, exp);
        end
    endtask

    // Drive at a falling edge; the decision is registered at the next rising edge
    // and is sampled at the falling edge after it.
    task automatic req(input logic v, input logic [ADDR_W-1:0] a, input logic [CORE_W-1:0] c);
        req_valid      = v;
        req_block_addr = a;
        req_core       = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        n_checks  = 0;
        n_fails   = 0;
        finished  = 1'b0;
        rst       = 1'b1;
        req_valid = 1'b0;
        req_block_addr = '0;
        req_core  = '0;
        repeat (3) @(negedge clk);
        check("R1", dec_valid, 1'b0, -1);
        check("R1", dec_local, 1'b0, -1);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            req(v[VEC_W-1], v[VEC_W-2 -: ADDR_W], v[CORE_W:1]);
            check("R2", dec_valid, v[VEC_W-1], i);
            check("R5", dec_local, v[0], i);
        end

        // Reset in the middle of a local streak on block 0x0005.
        req(1'b1, 16'h0005, 3'd3);
        check("R8", dec_local, 1'b1, 100);
        rst = 1'b1;
        req(1'b1, 16'h0005, 3'd3);
        check("R1", dec_valid, 1'b0, 101);
        check("R1", dec_local, 1'b0, 101);
        rst = 1'b0;
        req(1'b1, 16'h0005, 3'd3);
        check("R1", dec_valid, 1'b1, 102);
        check("R1", dec_local, 1'b0, 102);

        // R10: a run of idle cycles keeps dec_valid low.
        for (int i = 0; i < 3; i++) begin
            req(1'b0, 16'h0005, 3'd4);
            check("R10", dec_valid, 1'b0, 110 + i);
        end

        // Streak resumes from count 0: three more far, then local.
        for (int i = 0; i < 3; i++) begin
            req(1'b1, 16'h0005, 3'd3);
            check("R4", dec_local, 1'b0, 120 + i);
        end
        req(1'b1, 16'h0005, 3'd3);
        check("R5", dec_local, 1'b1, 123);

        // R7: highest index, independent from entry 5.
        req(1'b1, 16'hABCF, 3'd6);
        check("R7", dec_local, 1'b0, 130);
        req(1'b1, 16'h0005, 3'd3);
        check("R7", dec_local, 1'b1, 131);

        req(1'b0, '0, '0);
        finish_run();
    end

endmodule